// File: doc/BRIEF.md
# Memory-Mapped Flash Read Window Controller

This block sits between a simple bus read port and a serial flash command sequencer. Every accepted bus read is first checked against the configured flash capacity and the fixed addressable window. A read that passes the check is turned into a frame request for the sequencer. The request is one of three kinds: open a new frame, continue the frame already open, or close the open frame and reopen it at a new address. A read that fails the check completes at once with an error response and reaches no flash frame.

Chip select is kept active between reads, so a run of sequential reads streams through one open frame without a new command. Only three things release it. The first is a timeout: the prefetch buffer stays full past a programmable number of clock cycles. The second is a non-sequential address, which releases it and reopens it in the same cycle. The third is clearing the enable. A sticky timeout flag and a sticky transfer-error flag record what happened. Both flags clear when the block is disabled.

Top module: `mmap_read_window`

## Requirements
- R1: While reset is high and on the first cycle after it, every output is low, cs_active included.
- R2: With flash_size = N (0..31), an address is in range when every rd_addr bit at position N+1 or above is zero. The window is ADDR_W = 28 bits wide, so any N of 27 or more accepts the whole window.
- R3: An out-of-range read gives rd_done and rd_err high for one cycle on the cycle after the request and sets xfer_err_flag. It raises no frame pulse and leaves the open frame and its last address unchanged.
- R4: An in-range read while cs_active is low gives rd_done and frm_start on the next cycle, with frm_addr equal to the read address, and sets cs_active.
- R5: An in-range read while cs_active is high, whose address equals the last frame address plus one modulo 2^ADDR_W, gives rd_done and frm_cont only, with frm_addr equal to the read address.
- R6: Any other in-range read while cs_active is high gives rd_done, frm_stop and frm_start together in one cycle, and frm_cont stays low.
- R7: With tmo_en high and cs_active high, a buffer that is full for tmo_period+1 consecutive clock edges after the last reload gives frm_stop on the last of those edges, clears cs_active and sets tmo_flag. The next read then opens a new frame, even if its address is sequential.
- R8: A clock edge with buf_full low, or with an accepted read, reloads the timeout count. The count restarts, and an expiry due on the same edge as an accepted read does not happen.
- R9: With tmo_en low, cs_active stays high while enabled, however long buf_full stays high.
- R10: With enable low, an open frame is closed with one frm_stop pulse, both flags clear, and requests get no rd_done.
- R11: tmo_flag and xfer_err_flag stay set while enable stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable; low closes the frame and clears flags |
| rd_req | input | 1 | Single-cycle read request |
| rd_addr | input | ADDR_W | Read address inside the window |
| flash_size | input | SIZE_W | Flash size code N, capacity 2^(N+1) |
| tmo_period | input | TMO_W | Full-buffer timeout period in cycles |
| tmo_en | input | 1 | Timeout counter enable |
| buf_full | input | 1 | Prefetch buffer full |
| rd_done | output | 1 | Read completion pulse |
| rd_err | output | 1 | Error response with rd_done |
| frm_start | output | 1 | Open-frame request pulse |
| frm_cont | output | 1 | Continue-frame request pulse |
| frm_stop | output | 1 | Close-frame request pulse |
| frm_addr | output | ADDR_W | Address for start or continue |
| cs_active | output | 1 | Frame open (chip select asserted) |
| tmo_flag | output | 1 | Sticky timeout flag |
| xfer_err_flag | output | 1 | Sticky transfer-error flag |

## Verification
The bench builds the block with its default widths: a 28-bit window, a 5-bit size code and a 16-bit period. It programs periods of 0 and 5, so an expiry takes only one or six edges and its exact cycle can be checked. Size codes 0, 15 and 31 reach the smallest flash, a mid-size boundary and the case where the window cap takes over from the flash size. An address of all ones followed by zero reaches the wrap of the sequential-address test.

// File: rtl/mrw_pkg.sv
package mrw_pkg;
  // outcome of one accepted read
  typedef enum logic [1:0] {
    RD_ERROR  = 2'd0,
    RD_OPEN   = 2'd1,
    RD_CONT   = 2'd2,
    RD_REOPEN = 2'd3
  } rd_kind_t;
endpackage

// File: rtl/mrw_range.sv
module mrw_range #(
  parameter int ADDR_W = 28,
  parameter int SIZE_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] fsize,
  output logic              in_range
);
  localparam int NB_W = SIZE_W + 1;
  logic [NB_W-1:0] nbits;

  assign nbits = {1'b0, fsize} + {{(NB_W-1){1'b0}}, 1'b1};

  // any set bit at or above the decoded width is out of range;
  // the port width itself caps the window
  always_comb begin
    in_range = 1'b1;
    for (int i = 0; i < ADDR_W; i++) begin
      if ((i >= int'(nbits)) && addr[i]) in_range = 1'b0;
    end
  end
endmodule

// File: rtl/mrw_timeout.sv
module mrw_timeout #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             reload,
  input  logic [TMO_W-1:0] period,
  output logic             expire
);
  logic [TMO_W-1:0] cnt;

  assign expire = arm && !reload && (cnt == period);

  always_ff @(posedge clk) begin
    if (rst || reload || !arm || expire) cnt <= '0;
    else                                 cnt <= cnt + {{(TMO_W-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/mmap_read_window.sv
module mmap_read_window
  import mrw_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int SIZE_W = 5,
  parameter int TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [SIZE_W-1:0] flash_size,
  input  logic [TMO_W-1:0]  tmo_period,
  input  logic              tmo_en,
  input  logic              buf_full,
  output logic              rd_done,
  output logic              rd_err,
  output logic              frm_start,
  output logic              frm_cont,
  output logic              frm_stop,
  output logic [ADDR_W-1:0] frm_addr,
  output logic              cs_active,
  output logic              tmo_flag,
  output logic              xfer_err_flag
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic              accept, in_range, expire, arm, reload;
  logic [ADDR_W-1:0] last_addr, next_addr;
  rd_kind_t          kind;

  assign accept    = enable && rd_req;
  assign next_addr = last_addr + ONE;
  assign arm       = enable && tmo_en && cs_active && buf_full;
  assign reload    = accept || !buf_full;

  mrw_range #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) range_i (
    .addr(rd_addr), .fsize(flash_size), .in_range(in_range)
  );

  mrw_timeout #(.TMO_W(TMO_W)) tmo_i (
    .clk(clk), .rst(rst), .arm(arm), .reload(reload),
    .period(tmo_period), .expire(expire)
  );

  // continuation decision
  always_comb begin
    if (!in_range)                               kind = RD_ERROR;
    else if (!cs_active)                         kind = RD_OPEN;
    else if (rd_addr == next_addr)               kind = RD_CONT;
    else                                         kind = RD_REOPEN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_done <= 1'b0; rd_err <= 1'b0;
      frm_start <= 1'b0; frm_cont <= 1'b0; frm_stop <= 1'b0;
      frm_addr <= '0; last_addr <= '0;
      cs_active <= 1'b0; tmo_flag <= 1'b0; xfer_err_flag <= 1'b0;
    end else begin
      rd_done <= 1'b0; rd_err <= 1'b0;
      frm_start <= 1'b0; frm_cont <= 1'b0; frm_stop <= 1'b0;
      if (!enable) begin
        frm_stop      <= cs_active;
        cs_active     <= 1'b0;
        tmo_flag      <= 1'b0;
        xfer_err_flag <= 1'b0;
      end else if (accept) begin
        rd_done <= 1'b1;
        case (kind)
          RD_ERROR: begin
            rd_err        <= 1'b1;
            xfer_err_flag <= 1'b1;
          end
          RD_CONT: begin
            frm_cont  <= 1'b1;
            frm_addr  <= rd_addr;
            last_addr <= rd_addr;
          end
          default: begin
            frm_stop  <= (kind == RD_REOPEN);
            frm_start <= 1'b1;
            cs_active <= 1'b1;
            frm_addr  <= rd_addr;
            last_addr <= rd_addr;
          end
        endcase
      end else if (expire) begin
        frm_stop  <= 1'b1;
        cs_active <= 1'b0;
        tmo_flag  <= 1'b1;
      end
    end
  end

  // R6
  cont_excl_start_chk: assert property (@(posedge clk) disable iff (rst)
    !(frm_cont && (frm_start || frm_stop)));
  // R3
  err_no_frame_chk: assert property (@(posedge clk) disable iff (rst)
    rd_err |-> !(frm_start || frm_cont) && rd_done);
  // R11
  tmo_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (tmo_flag && enable) |=> tmo_flag);
  // R7
  tmo_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tmo_flag) |-> (frm_stop && !cs_active));
  // R9
  hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_active && enable && !tmo_en) |=> cs_active);
  // R10
  done_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    rd_done |-> $past(rd_req && enable));
endmodule

// File: tb/mmap_read_window_tb_top.sv
module mmap_read_window_tb_top;
  localparam int AW = 28;

  logic          clk = 1'b0, rst = 1'b1;
  logic          enable = 1'b0, rd_req = 1'b0, tmo_en = 1'b0, buf_full = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [4:0]    flash_size = 5'd31;
  logic [15:0]   tmo_period = 16'd5;
  logic          rd_done, rd_err, frm_start, frm_cont, frm_stop;
  logic [AW-1:0] frm_addr;
  logic          cs_active, tmo_flag, xfer_err_flag;

  always #10 clk = ~clk;

  mmap_read_window dut_i (
    .clk(clk), .rst(rst), .enable(enable), .rd_req(rd_req), .rd_addr(rd_addr),
    .flash_size(flash_size), .tmo_period(tmo_period), .tmo_en(tmo_en),
    .buf_full(buf_full), .rd_done(rd_done), .rd_err(rd_err),
    .frm_start(frm_start), .frm_cont(frm_cont), .frm_stop(frm_stop),
    .frm_addr(frm_addr), .cs_active(cs_active), .tmo_flag(tmo_flag),
    .xfer_err_flag(xfer_err_flag)
  );

  typedef struct {
    logic [4:0]    ev;   // {done, err, start, cont, stop}
    logic [AW-1:0] a;
    bit            ca;
    int            rq;
  } item_t;

  item_t         q[$];
  int            nvec = 0, nfail = 0;
  bit            m_cs = 1'b0;
  logic [AW-1:0] m_last = '0;
  logic [4:0]    mon_ev;
  item_t         mon_it;

  task automatic chk(input logic [AW-1:0] act, input logic [AW-1:0] exp, input int rq);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL R%0d: actual %h expected %h", rq, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      mon_ev = {rd_done, rd_err, frm_start, frm_cont, frm_stop};
      if (mon_ev != 5'b0) begin
        nvec++;
        if (q.size() == 0) begin
          nfail++;
          $display("FAIL R10: unexpected event actual %b expected none", mon_ev);
        end else begin
          mon_it = q.pop_front();
          if (mon_ev !== mon_it.ev || (mon_it.ca && frm_addr !== mon_it.a)) begin
            nfail++;
            $display("FAIL R%0d: actual ev %b addr %h expected ev %b addr %h",
                     mon_it.rq, mon_ev, frm_addr, mon_it.ev, mon_it.a);
          end
        end
      end
    end
  end

  // driver: computes the expected outcome from the requirements
  task automatic do_read(input logic [AW-1:0] a);
    item_t it;
    bit    inr;
    inr = (flash_size >= 5'd27) || ((a >> (int'(flash_size) + 1)) == 0);
    it.a = a; it.ca = 1'b1;
    if (!inr) begin
      it.ev = 5'b11000; it.ca = 1'b0; it.rq = 3;                // R2 R3
    end else if (m_cs && a == m_last + 28'd1) begin
      it.ev = 5'b10010; it.rq = 5; m_last = a;                 // R5
    end else if (m_cs) begin
      it.ev = 5'b10101; it.rq = 6; m_last = a;                 // R6
    end else begin
      it.ev = 5'b10100; it.rq = 4; m_cs = 1'b1; m_last = a;    // R4
    end
    q.push_back(it);
    rd_addr = a; rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic push_stop(input int rq);
    item_t it;
    it.ev = 5'b00001; it.a = '0; it.ca = 1'b0; it.rq = rq;
    q.push_back(it);
    m_cs = 1'b0;
  endtask

  bit finished = 1'b0;

  initial begin
    #(200000 * 20);
    if (!finished) begin
      nfail++;
      $display("FAIL R1: watchdog expired actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(cs_active, 0, 1); chk(tmo_flag, 0, 1); chk(xfer_err_flag, 0, 1);
    chk({rd_done, rd_err, frm_start, frm_cont, frm_stop}, 0, 1);
    enable = 1'b1; tmo_en = 1'b1; flash_size = 5'd31; tmo_period = 16'd5;
    @(negedge clk);

    // R4 open, R5 continue, R6 reopen
    do_read(28'h0000100);
    do_read(28'h0000101);
    do_read(28'h0000102);
    do_read(28'h0000200);
    chk(cs_active, 1, 4);
    // R5 wrap of the sequential test, R2 size 31 limited by window
    do_read(28'hFFFFFFF);
    do_read(28'h0000000);

    // R2 R3 out of range with size 15 (16 address bits)
    flash_size = 5'd15;
    do_read(28'h0010000);
    chk(xfer_err_flag, 1, 3);
    chk(cs_active, 1, 3);
    do_read(28'h0000001);        // frame untouched: continues from 0
    do_read(28'h000FFFF);
    flash_size = 5'd0;           // R2 smallest flash: 0 and 1 only
    do_read(28'h0000002);
    do_read(28'h0000001);
    chk(xfer_err_flag, 1, 11);   // R11 sticky
    flash_size = 5'd31;

    // R7 timeout after period+1 full edges
    buf_full = 1'b1;
    repeat (5) @(negedge clk);
    chk(cs_active, 1, 7);
    push_stop(7);
    @(negedge clk);
    chk(cs_active, 0, 7);
    chk(tmo_flag, 1, 7);
    buf_full = 1'b0;
    do_read(m_last + 28'd1);     // R7 sequential yet opens a new frame
    chk(tmo_flag, 1, 11);        // R11

    // R8 reload by empty buffer and by accepted read
    buf_full = 1'b1;
    repeat (4) @(negedge clk);
    buf_full = 1'b0;
    @(negedge clk);
    buf_full = 1'b1;
    repeat (5) @(negedge clk);
    chk(cs_active, 1, 8);
    do_read(m_last + 28'd1);
    repeat (5) @(negedge clk);
    chk(cs_active, 1, 8);
    push_stop(8);
    @(negedge clk);
    chk(cs_active, 0, 8);
    buf_full = 1'b0;

    // R7 period 0 expires on the first full edge
    tmo_period = 16'd0;
    do_read(28'h0000400);
    buf_full = 1'b1;
    push_stop(7);
    @(negedge clk);
    chk(cs_active, 0, 7);
    buf_full = 1'b0;

    // R9 timeout disabled holds the frame
    tmo_en = 1'b0;
    do_read(28'h0000500);
    buf_full = 1'b1;
    repeat (50) @(negedge clk);
    chk(cs_active, 1, 9);
    buf_full = 1'b0;

    // R10 disable closes, clears, ignores
    enable = 1'b0;
    push_stop(10);
    @(negedge clk);
    chk(cs_active, 0, 10);
    chk(tmo_flag, 0, 10);
    chk(xfer_err_flag, 0, 10);
    rd_addr = 28'h0000600; rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    chk(rd_done, 0, 10);
    enable = 1'b1;
    do_read(28'h0000601);
    chk(cs_active, 1, 4);
    repeat (3) @(negedge clk);

    chk(q.size(), 0, 4);
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule